// File: doc/BRIEF.md
# I2C Byte-Memory Target Engine

This block is the protocol front end of a small byte-addressed memory reached over a two-wire I2C bus. It watches the clock and data lines, which arrive already synchronized to a faster system clock. It finds bus START and STOP conditions and collects the device address byte. When the address matches, it acknowledges by pulling the data line low. In a write, it takes the next byte as the memory pointer. Every byte after that becomes a one-cycle write request toward the memory, and the pointer advances after each one. In a read, it serializes bytes fetched through a combinational read port, most significant bit first, for as long as the bus master keeps acknowledging.

A repeated START restarts address reception without a STOP. A master can therefore load the pointer with a short write and then switch straight to a read (a random read). A busy input from the memory side holds the engine silent and idle, for example while a nonvolatile programming cycle runs. Open-drain behaviour is reduced to a single drive-low enable.

Top module: `i2c_mem_target`

## Requirements
- R1: A falling data edge while the clock is high (START) begins address reception, in any state, including in the middle of a transaction. Without a START, no byte is acknowledged.
- R2: A rising data edge while the clock is high (STOP) releases the data line and returns the engine to idle. After reset the line is released, no write request is pending, and the pointer is 0.
- R3: The first byte after START is compared, bits 7..1, with the 7-bit device address 1010000. On a match, the engine drives the data line low for the ninth clock. Bit 0 selects read (1) or write (0).
- R4: A non-matching address byte gets no acknowledge. Later bytes are ignored and cause no write request until the next START.
- R5: In a write, the byte after the address byte loads the memory pointer and is acknowledged.
- R6: Each further write byte produces a single-cycle write request. The request carries the current pointer and the byte, is acknowledged, and advances the pointer by one.
- R7: In a read, the engine sends the byte at the pointer, most significant bit first, and the pointer advances after each byte. A low (ACK) from the master on the ninth clock makes the engine send the next byte.
- R8: A high (NACK) from the master on the ninth clock of a read leaves the data line released until the next START.
- R9: The pointer wraps from 255 to 0, for both reads and writes.
- R10: While the busy input is high, the engine drives nothing, acknowledges nothing, issues no write request, and ignores START.
- R11: The engine changes its drive on the data line only while the clock is low. Its acknowledge drive is already in place before the ninth rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Synchronized bus clock |
| sdaIn | input | 1 | Synchronized bus data (resolved line level) |
| sdaDriveLow | output | 1 | Pull the data line low when 1 |
| memBusy | input | 1 | Memory busy; the engine stays silent while high |
| rdAddr | output | ADDR_W (8) | Read address, equal to the pointer |
| rdData | input | 8 | Combinational read data for rdAddr |
| wrReq | output | 1 | One-cycle byte write request |
| wrAddr | output | ADDR_W (8) | Write address |
| wrData | output | 8 | Write data |

## Verification
Some properties are checked on every cycle:
- the data line is released one cycle after a START, a STOP or a busy cycle;
- no write request appears while busy;
- a drive change never follows a sampled high clock;
- write requests are single pulses that leave the pointer one past the written address.

Other behaviour shows up only in the bench's bus scenarios:
- address matching and acknowledge placement;
- pointer loading;
- read sequencing, with bytes checked against an independently kept memory image;
- the repeated-START random read;
- wrap-around at 255;
- silence after a master NACK, after a STOP and while busy.

// File: rtl/i2c_mem_pkg.sv
`timescale 1ns/1ps
package i2c_mem_pkg;
  localparam int BYTE_W = 8;

  // Bus events seen by the datapath, consumed by the control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic byteFull;
    logic devMatch;
    logic rwBit;
    logic sdaNow;
  } busEvt_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic cntClr;
    logic shiftIn;
    logic txLoad;
    logic txShift;
    logic ackOn;
    logic relOn;
    logic ptrLoad;
    logic ptrInc;
    logic wrFire;
  } dpCmd_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEVACK, ST_PTR, ST_PTRACK,
    ST_WR, ST_WRACK, ST_RD, ST_RDACK
  } state_t;
endpackage

// File: rtl/i2c_mem_dp.sv
`timescale 1ns/1ps
module i2c_mem_dp
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [6:0] DEV_ADDR = 7'b1010000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rdData,
  input  dpCmd_t            cmd,
  output busEvt_t           evt,
  output logic              sdaDriveLow,
  output logic [ADDR_W-1:0] ptr,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [BYTE_W-1:0] wrData
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  logic sclQ, sdaQ;
  logic [BYTE_W-1:0] shiftReg;
  logic [CNT_W-1:0] bitCnt;

  assign evt.sclRise   = sclIn & ~sclQ;
  assign evt.sclFall   = ~sclIn & sclQ;
  assign evt.startSeen = sclIn & sclQ & sdaQ & ~sdaIn;
  assign evt.stopSeen  = sclIn & sclQ & ~sdaQ & sdaIn;
  assign evt.byteFull  = (bitCnt == CNT_FULL);
  assign evt.devMatch  = (shiftReg[BYTE_W-1:1] == DEV_ADDR);
  assign evt.rwBit     = shiftReg[0];
  assign evt.sdaNow    = sdaIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ        <= 1'b1;
      sdaQ        <= 1'b1;
      shiftReg    <= '0;
      bitCnt      <= '0;
      sdaDriveLow <= 1'b0;
      ptr         <= '0;
      wrReq       <= 1'b0;
      wrAddr      <= '0;
      wrData      <= '0;
    end else begin
      sclQ  <= sclIn;
      sdaQ  <= sdaIn;
      wrReq <= cmd.wrFire;
      if (cmd.wrFire) begin
        wrAddr <= ptr;
        wrData <= shiftReg;
      end
      if (cmd.ptrLoad) ptr <= shiftReg[ADDR_W-1:0];
      else if (cmd.ptrInc) ptr <= ptr + 1'b1;

      if (cmd.cntClr) bitCnt <= '0;
      else if (evt.sclRise && !evt.byteFull) bitCnt <= bitCnt + 1'b1;

      if (cmd.txLoad) shiftReg <= rdData;
      else if (cmd.txShift) shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
      else if (cmd.shiftIn && evt.sclRise) shiftReg <= {shiftReg[BYTE_W-2:0], sdaIn};

      if (cmd.relOn) sdaDriveLow <= 1'b0;
      else if (cmd.ackOn) sdaDriveLow <= 1'b1;
      else if (cmd.txLoad) sdaDriveLow <= ~rdData[BYTE_W-1];
      else if (cmd.txShift) sdaDriveLow <= ~shiftReg[BYTE_W-2];
    end
  end

  // R6: a write request lasts one cycle
  p_wr_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> !wrReq);

  // R6: pointer stands one past the address just written
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |-> (ptr == wrAddr + 1'b1));
endmodule

// File: rtl/i2c_mem_ctrl.sv
`timescale 1ns/1ps
module i2c_mem_ctrl
  import i2c_mem_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    memBusy,
  input  busEvt_t evt,
  output dpCmd_t  cmd
);
  state_t state, nextState;
  logic rwReg, mNack;

  always_comb begin
    cmd = '0;
    nextState = state;
    if (memBusy) begin
      nextState = ST_IDLE;
      cmd.relOn = 1'b1;
    end else if (evt.startSeen) begin
      nextState  = ST_DEV;
      cmd.cntClr = 1'b1;
      cmd.relOn  = 1'b1;
    end else if (evt.stopSeen) begin
      nextState = ST_IDLE;
      cmd.relOn = 1'b1;
    end else begin
      case (state)
        ST_DEV: begin
          cmd.shiftIn = 1'b1;
          if (evt.sclFall && evt.byteFull) begin
            if (evt.devMatch) begin
              nextState = ST_DEVACK;
              cmd.ackOn = 1'b1;
            end else begin
              nextState = ST_IDLE;
            end
          end
        end
        ST_DEVACK: if (evt.sclFall) begin
          cmd.cntClr = 1'b1;
          if (rwReg) begin
            cmd.txLoad = 1'b1;
            nextState  = ST_RD;
          end else begin
            cmd.relOn = 1'b1;
            nextState = ST_PTR;
          end
        end
        ST_PTR: begin
          cmd.shiftIn = 1'b1;
          if (evt.sclFall && evt.byteFull) begin
            cmd.ptrLoad = 1'b1;
            cmd.ackOn   = 1'b1;
            nextState   = ST_PTRACK;
          end
        end
        ST_PTRACK, ST_WRACK: if (evt.sclFall) begin
          cmd.relOn  = 1'b1;
          cmd.cntClr = 1'b1;
          nextState  = ST_WR;
        end
        ST_WR: begin
          cmd.shiftIn = 1'b1;
          if (evt.sclFall && evt.byteFull) begin
            cmd.wrFire = 1'b1;
            cmd.ptrInc = 1'b1;
            cmd.ackOn  = 1'b1;
            nextState  = ST_WRACK;
          end
        end
        ST_RD: if (evt.sclFall) begin
          if (evt.byteFull) begin
            cmd.relOn  = 1'b1;
            cmd.ptrInc = 1'b1;
            nextState  = ST_RDACK;
          end else begin
            cmd.txShift = 1'b1;
          end
        end
        ST_RDACK: if (evt.sclFall) begin
          if (!mNack) begin
            cmd.txLoad = 1'b1;
            cmd.cntClr = 1'b1;
            nextState  = ST_RD;
          end else begin
            nextState = ST_IDLE;
          end
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      rwReg <= 1'b0;
      mNack <= 1'b1;
    end else begin
      state <= nextState;
      if (state == ST_DEV && nextState == ST_DEVACK) rwReg <= evt.rwBit;
      if (state == ST_RDACK && evt.sclRise) mNack <= evt.sdaNow;
    end
  end
endmodule

// File: rtl/i2c_mem_target.sv
`timescale 1ns/1ps
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [6:0] DEV_ADDR = 7'b1010000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  input  logic              memBusy,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdData,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData
);
  busEvt_t evt;
  dpCmd_t  cmd;

  i2c_mem_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .memBusy(memBusy), .evt(evt), .cmd(cmd)
  );

  i2c_mem_dp #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .rdData(rdData),
    .cmd(cmd), .evt(evt), .sdaDriveLow(sdaDriveLow), .ptr(rdAddr),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData)
  );

  // R1: a START leaves the line released
  p_start_release_r1: assert property (@(posedge clk) disable iff (!rstN)
    evt.startSeen |=> !sdaDriveLow);

  // R2: a STOP leaves the line released
  p_stop_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    evt.stopSeen |=> !sdaDriveLow);

  // R10: busy silences the engine
  p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    memBusy |=> (!sdaDriveLow && !wrReq));

  // R11: drive changes only follow a low clock sample
  p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(memBusy) && !$stable(sdaDriveLow)) |-> !$past(sclIn));
endmodule

// File: tb/sim_i2c_mem_target.sv
`timescale 1ns/1ps
module sim_i2c_mem_target;
  localparam int Q = 8;
  localparam int NVEC = 9;
  // {device byte, pointer byte, data byte, expected address ack}
  localparam logic [24:0] VEC [NVEC] = '{
    {8'hA0, 8'h03, 8'h11, 1'b1},
    {8'hA0, 8'h4A, 8'h5C, 1'b1},
    {8'hA2, 8'h10, 8'h99, 1'b0},
    {8'hA0, 8'h80, 8'hE7, 1'b1},
    {8'hB0, 8'h20, 8'h55, 1'b0},
    {8'hA0, 8'hC1, 8'h00, 1'b1},
    {8'h20, 8'h30, 8'h66, 1'b0},
    {8'hA8, 8'h40, 8'h77, 1'b0},
    {8'hA0, 8'h7F, 8'hFF, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mLow = 1'b0;
  logic busy = 1'b0;
  logic sdaDriveLow, wrReq;
  logic [7:0] rdAddr, wrAddr, wrData, rdData;
  logic sdaBus;
  logic [7:0] mem [256];
  logic [7:0] expMem [256];
  int wrCount = 0;
  logic [7:0] lastWrA = '0, lastWrD = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign sdaBus = !(mLow || sdaDriveLow);
  assign rdData = mem[rdAddr];

  i2c_mem_target u0 (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .memBusy(busy), .rdAddr(rdAddr),
    .rdData(rdData), .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData)
  );

  always @(posedge clk) if (wrReq) begin
    mem[wrAddr] <= wrData;
    wrCount <= wrCount + 1;
    lastWrA <= wrAddr;
    lastWrD <= wrData;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic halfWait;
    repeat (Q) @(negedge clk);
  endtask

  task automatic mStart;
    mLow = 0; halfWait; scl = 1; halfWait; mLow = 1; halfWait; scl = 0; halfWait;
  endtask

  task automatic mStop;
    mLow = 1; halfWait; scl = 1; halfWait; mLow = 0; halfWait;
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack, output bit early);
    for (int i = 7; i >= 0; i--) begin
      mLow = !b[i]; halfWait; scl = 1; halfWait; scl = 0;
    end
    mLow = 0; halfWait; early = sdaDriveLow; scl = 1; halfWait;
    ack = !sdaBus; scl = 0;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    mLow = 0;
    for (int i = 7; i >= 0; i--) begin
      halfWait; scl = 1; halfWait; b[i] = sdaBus; scl = 0;
    end
    mLow = giveAck; halfWait; scl = 1; halfWait; scl = 0; halfWait;
    mLow = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ack, early;
    logic [7:0] rb;
    int wc;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; expMem[i] = 8'h00; end
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R2: reset state
    chk(sdaDriveLow == 0, "R2 reset drive", sdaDriveLow, 0);
    chk(wrReq == 0, "R2 reset wrReq", wrReq, 0);
    chk(rdAddr == 0, "R2 reset pointer", rdAddr, 0);
    halfWait;

    // Table walk: R3 R4 R5 R6 R11
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] dv, pv, dt;
      bit ea;
      {dv, pv, dt, ea} = VEC[v];
      mStart;
      sendByte(dv, ack, early);
      chk(ack == ea, "R3 R4 address ack", ack, ea);
      chk(early == ea, "R11 ack drive before rise", early, ea);
      wc = wrCount;
      sendByte(pv, ack, early);
      chk(ack == ea, "R5 pointer ack", ack, ea);
      sendByte(dt, ack, early);
      chk(ack == ea, "R6 data ack", ack, ea);
      halfWait;
      if (ea) begin
        expMem[pv] = dt;
        chk(wrCount == wc + 1, "R6 one write", wrCount, wc + 1);
        chk(lastWrA == pv, "R6 write addr", lastWrA, pv);
        chk(lastWrD == dt, "R6 write data", lastWrD, dt);
      end else begin
        chk(wrCount == wc, "R4 no write", wrCount, wc);
      end
      mStop;
    end

    // R1 R7: random read through a repeated START
    mStart; sendByte(8'hA0, ack, early); sendByte(8'h03, ack, early);
    mStart; sendByte(8'hA1, ack, early);
    chk(ack == 1, "R1 repeated start ack", ack, 1);
    recvByte(1, rb); chk(rb == expMem[8'h03], "R7 read byte 0", rb, expMem[8'h03]);
    recvByte(0, rb); chk(rb == expMem[8'h04], "R7 read byte 1", rb, expMem[8'h04]);
    mStop;

    // R9: page write across 255
    wc = wrCount;
    mStart; sendByte(8'hA0, ack, early); sendByte(8'hFE, ack, early);
    sendByte(8'h21, ack, early); sendByte(8'h32, ack, early);
    sendByte(8'h43, ack, early); sendByte(8'h54, ack, early);
    halfWait; mStop;
    expMem[8'hFE] = 8'h21; expMem[8'hFF] = 8'h32; expMem[8'h00] = 8'h43; expMem[8'h01] = 8'h54;
    chk(wrCount == wc + 4, "R9 write count", wrCount, wc + 4);
    chk(mem[8'h00] == 8'h43, "R9 write wrap", mem[8'h00], 8'h43);

    // R9: read across 255
    mStart; sendByte(8'hA0, ack, early); sendByte(8'hFE, ack, early);
    mStart; sendByte(8'hA1, ack, early);
    recvByte(1, rb); chk(rb == 8'h21, "R7 read FE", rb, 8'h21);
    recvByte(1, rb); chk(rb == 8'h32, "R9 read FF", rb, 8'h32);
    recvByte(0, rb); chk(rb == 8'h43, "R9 read wrap 00", rb, 8'h43);
    // R8: released after NACK
    for (int k = 0; k < 9; k++) begin
      halfWait; scl = 1; halfWait;
      chk(sdaBus == 1, "R8 silent after nack", sdaBus, 1);
      scl = 0;
    end
    halfWait; mStop;

    // R7: current-address read continues at pointer 01
    mStart; sendByte(8'hA1, ack, early);
    recvByte(0, rb); chk(rb == 8'h54, "R7 current read", rb, 8'h54);
    mStop;

    // R10: busy ignores everything
    busy = 1; wc = wrCount;
    mStart; sendByte(8'hA0, ack, early);
    chk(ack == 0, "R10 busy no ack", ack, 0);
    sendByte(8'h05, ack, early); sendByte(8'hAA, ack, early);
    halfWait;
    chk(wrCount == wc, "R10 busy no write", wrCount, wc);
    busy = 0; halfWait;
    // R1: no START seen since busy ended
    sendByte(8'hA0, ack, early);
    chk(ack == 0, "R1 no start no ack", ack, 0);
    mStop;

    // R2: STOP mid-write returns to idle
    mStart; sendByte(8'hA0, ack, early); sendByte(8'h60, ack, early);
    mStop;
    chk(sdaDriveLow == 0, "R2 released after stop", sdaDriveLow, 0);
    scl = 0; halfWait;
    sendByte(8'hA0, ack, early);
    chk(ack == 0, "R2 idle after stop", ack, 0);
    mStop;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule